// File: doc/BRIEF.md
# Burst Pseudo-Static RAM Bus Controller

This block sits on the host side of a pseudo-static RAM that shares sixteen lines between address and data. The upper address bits go out on their own pins. The host issues one request at a time on a simple valid/ready port. A request carries an address, one write data word, byte enables, a read/write flag, a burst length and a flag that selects the configuration register instead of the array. The controller turns each request into the strobe sequence the memory expects: chip enable, address valid, output enable, write enable, configuration-register enable and the two byte enables. It also drives the memory clock enable and decides, cycle by cycle, whether the host drives the shared lines or releases them.

The controller keeps its own copy of two configuration bits. Bit 15 selects the protocol: 1 means asynchronous and 0 means synchronous burst. Bit 10 sets the polarity of the memory's WAIT output. The copy is updated when a configuration register write completes.

In asynchronous mode every array access takes a fixed number of strobe cycles and the memory clock stays static. In synchronous mode array accesses run with the memory clock enabled. A burst read then accepts one word on each clock where WAIT is not asserted, until the requested number of words has arrived.

Top module: `psram_bus_ctrl`

## Requirements
- R1: During and right after reset, the outputs are in these states: mem_ce_n, mem_adv_n, mem_oe_n and mem_we_n high; mem_cre, adq_oe, mem_clk_en and rsp_valid low; req_ready high. The controller starts in asynchronous mode (cfg_sync=0) with active-high WAIT (cfg_wait_hi=1).
- R2: Every access begins with exactly one address cycle. In that cycle mem_ce_n and mem_adv_n are low, adq_oe is high, adq_out carries address bits 15..0 and mem_addr_hi carries the remaining upper bits. mem_adv_n is high in every other cycle.
- R3: Before a read, the controller spends one cycle with adq_oe low and mem_oe_n still high. adq_oe and a low mem_oe_n never occur in the same cycle.
- R4: An asynchronous read, whether to the array or to the register, holds mem_oe_n low for ACC_CYC cycles (default 4). It captures adq_in in the last of those cycles, and rsp_valid pulses with that word in the following cycle. An array read in asynchronous mode returns exactly one word, whatever req_len says.
- R5: An asynchronous write holds mem_we_n low for ACC_CYC cycles, with adq_oe high and the write word on adq_out. The byte enables follow the request: mem_ub_n is the inverse of req_be[1] and mem_lb_n is the inverse of req_be[0].
- R6: A register access (req_reg=1) always uses the asynchronous timing. mem_cre is high and both byte enables are low while chip enable is low. A register write with value v sets cfg_sync to the inverse of v[15] and cfg_wait_hi to v[10]. Both changes are visible in the cycle after the last write-enable cycle.
- R7: In synchronous mode, mem_clk_en is high exactly while chip enable is low during an array access. In asynchronous mode mem_clk_en is always low.
- R8: In a synchronous burst read, WAIT counts as asserted when mem_wait equals cfg_wait_hi. mem_oe_n stays low, and a word is taken from adq_in on each cycle where WAIT is not asserted; it appears on rsp_data with rsp_valid one cycle later. After req_len words (a req_len of 0 counts as 1), chip enable rises.
- R9: A synchronous write drives mem_we_n low in the address cycle and in each data cycle. The write word stays on adq_out until a cycle in which WAIT is not asserted, and chip enable rises after that cycle.
- R10: Every access ends with one cycle where chip enable is high before the controller returns to idle, so chip enable is high for at least two cycles between accesses. req_ready is high only in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | 1 = configuration register, 0 = array |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write word or register value |
| req_be | input | 2 | Byte enables, bit 1 upper, bit 0 lower |
| req_len | input | LW | Burst read length in words, 0 counts as 1 |
| rsp_valid | output | 1 | Read word valid |
| rsp_data | output | 16 | Read word |
| cfg_sync | output | 1 | 1 = synchronous burst mode in effect |
| cfg_wait_hi | output | 1 | 1 = WAIT asserted when high |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cre | output | 1 | Configuration register enable |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_clk_en | output | 1 | Memory clock enable |
| mem_addr_hi | output | AW-16 | Upper address pins |
| adq_out | output | 16 | Value driven on the shared lines |
| adq_oe | output | 1 | Host drives the shared lines |
| adq_in | input | 16 | Value read from the shared lines |
| mem_wait | input | 1 | WAIT from the memory |

## Verification
The hardest case to reach from the ports is a synchronous burst read under active-low WAIT with stalls in the middle of the burst. Getting there takes two register writes: one switches to synchronous mode and one clears the polarity bit. Only after both does a burst read run with a chosen pattern of stalled cycles. The bench follows this order, driving WAIT from a per-access bit pattern at the level the programmed polarity calls for. It also covers bursts stalled on their first cycle, a zero length and a write held off by WAIT. At the end it switches back to asynchronous mode to check that the clock goes static again.

// File: rtl/psram_bus_ctrl.sv
module psram_bus_ctrl #(
  parameter int AW      = 21,
  parameter int LW      = 6,
  parameter int ACC_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_reg,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  input  logic [LW-1:0] req_len,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic          cfg_sync,
  output logic          cfg_wait_hi,
  output logic          mem_ce_n,
  output logic          mem_adv_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_cre,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic          mem_clk_en,
  output logic [AW-17:0] mem_addr_hi,
  output logic [15:0]   adq_out,
  output logic          adq_oe,
  input  logic [15:0]   adq_in,
  input  logic          mem_wait
);

  localparam int ACW = $clog2(ACC_CYC) + 1;
  localparam int CW  = (LW > ACW) ? LW : ACW;
  localparam logic [CW-1:0] ACC_LAST = CW'(ACC_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_TURN, S_ARD, S_AWR, S_BRD, S_BWR, S_RECOV
  } st_t;

  st_t            st;
  logic [CW-1:0]  cnt, last_q;
  logic [AW-1:0]  addr_q;
  logic [15:0]    wdata_q;
  logic [1:0]     be_q;
  logic           wr_q, reg_q, burst_q;
  logic           wait_act;

  assign wait_act  = (mem_wait == cfg_wait_hi);
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      last_q      <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      wr_q        <= 1'b0;
      reg_q       <= 1'b0;
      burst_q     <= 1'b0;
      cfg_sync    <= 1'b0;
      cfg_wait_hi <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          wr_q    <= req_write;
          reg_q   <= req_reg;
          burst_q <= cfg_sync & ~req_reg;
          last_q  <= (req_len == '0) ? '0 : CW'(req_len - 1'b1);
          st      <= S_ADDR;
        end
        S_ADDR: begin
          cnt <= '0;
          st  <= wr_q ? (burst_q ? S_BWR : S_AWR) : S_TURN;
        end
        S_TURN: begin
          cnt <= '0;
          st  <= burst_q ? S_BRD : S_ARD;
        end
        S_ARD: begin
          cnt <= cnt + 1'b1;
          if (cnt == ACC_LAST) begin
            rsp_valid <= 1'b1;
            rsp_data  <= adq_in;
            st        <= S_RECOV;
          end
        end
        S_AWR: begin
          cnt <= cnt + 1'b1;
          if (cnt == ACC_LAST) begin
            st <= S_RECOV;
            if (reg_q) begin
              cfg_sync    <= ~wdata_q[15];
              cfg_wait_hi <= wdata_q[10];
            end
          end
        end
        S_BRD: if (!wait_act) begin
          rsp_valid <= 1'b1;
          rsp_data  <= adq_in;
          cnt       <= cnt + 1'b1;
          if (cnt == last_q) st <= S_RECOV;
        end
        S_BWR: if (!wait_act) st <= S_RECOV;
        S_RECOV: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_ce_n    = (st == S_IDLE) || (st == S_RECOV);
  assign mem_adv_n   = (st != S_ADDR);
  assign mem_oe_n    = !((st == S_ARD) || (st == S_BRD));
  assign mem_we_n    = !((st == S_AWR) || (st == S_BWR) ||
                         ((st == S_ADDR) && wr_q && burst_q));
  assign mem_cre     = reg_q && !mem_ce_n;
  assign mem_clk_en  = burst_q && !mem_ce_n;
  assign adq_oe      = (st == S_ADDR) || (st == S_AWR) || (st == S_BWR);
  assign adq_out     = (st == S_ADDR) ? addr_q[15:0] : wdata_q;
  assign mem_addr_hi = addr_q[AW-1:16];
  assign {mem_ub_n, mem_lb_n} = mem_ce_n ? 2'b11 :
                                ((wr_q && !reg_q) ? ~be_q : 2'b00);

  a_r3_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(adq_oe && !mem_oe_n));
  a_r3_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(adq_oe));
  a_r2_adv_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);
  a_r7_static_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sync |-> !mem_clk_en);
  a_r6_cre_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cre |-> !mem_ce_n);
  a_r8_wait_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(mem_clk_en)) |-> ($past(mem_wait) != $past(cfg_wait_hi)));
  a_r10_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n);

endmodule

// File: tb/tb_psram_bus_ctrl.sv
`timescale 1ns/1ps
module tb_psram_bus_ctrl;
  localparam int AW = 21, LW = 6, ACC = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_reg = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, adq_in = '0;
  logic [1:0] req_be = '0;
  logic [LW-1:0] req_len = '0;
  logic mem_wait = 0;
  logic req_ready, rsp_valid, cfg_sync, cfg_wait_hi;
  logic [15:0] rsp_data, adq_out;
  logic mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_cre, mem_ub_n, mem_lb_n;
  logic mem_clk_en, adq_oe;
  logic [AW-17:0] mem_addr_hi;

  psram_bus_ctrl #(.AW(AW), .LW(LW), .ACC_CYC(ACC)) dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit m_sync = 0, m_whi = 1;
  bit pend_v = 0;
  logic [15:0] pend_d = '0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [6:0] pins();
    return {mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_cre, adq_oe, mem_clk_en};
  endfunction

  task automatic step(input string r, input logic [6:0] ep, input logic [1:0] eb,
                      input int eadq, input bit asrt, input logic [15:0] din,
                      input bit nrv, input logic [15:0] nrd);
    chk({r, " pins"}, pins(), ep);
    chk({r, " bytes"}, {mem_ub_n, mem_lb_n}, eb);
    if (eadq >= 0) chk({r, " adq"}, adq_out, eadq[15:0]);
    chk({r, " rsp_valid"}, rsp_valid, pend_v);
    if (pend_v) chk({r, " rsp_data"}, rsp_data, pend_d);
    mem_wait = asrt ? m_whi : !m_whi;
    adq_in = din;
    pend_v = nrv;
    pend_d = nrd;
    @(negedge clk);
  endtask

  task automatic access(input bit wr, input bit rg, input logic [AW-1:0] a,
                        input logic [15:0] d, input logic [1:0] be,
                        input logic [LW-1:0] len, input logic [15:0] wp);
    bit bst = m_sync && !rg;
    logic [1:0] by = (wr && !rg) ? ~be : 2'b00;
    logic [15:0] din;
    int n, k, i;
    chk("R10 idle ready", req_ready, 1'b1);
    chk("R10 idle ce", mem_ce_n, 1'b1);
    req_valid = 1; req_write = wr; req_reg = rg; req_addr = a;
    req_wdata = d; req_be = be; req_len = len;
    @(negedge clk);
    req_valid = 0;
    chk("R2 addr_hi", mem_addr_hi, a[AW-1:16]);
    chk("R10 busy ready", req_ready, 1'b0);
    step("R2", {2'b00, 1'b1, !(wr && bst), rg, 1'b1, bst}, by, int'(a[15:0]), 0, 16'h0, 0, 16'h0);
    if (wr) begin
      if (!bst) begin
        for (int j = 0; j < ACC; j++)
          step(rg ? "R6" : "R5", {4'b0110, rg, 2'b10}, by, int'(d), 0, 16'h0, 0, 16'h0);
      end else begin
        i = 0;
        while (1) begin
          step("R9", 7'b0110011, by, int'(d), wp[i], 16'h0, 0, 16'h0);
          if (!wp[i]) break;
          i++;
        end
      end
    end else begin
      step("R3", {4'b0111, rg, 1'b0, bst}, by, -1, 0, 16'h0, 0, 16'h0);
      if (!bst) begin
        for (int j = 0; j < ACC; j++) begin
          din = {a[7:0], 8'h00} ^ 16'h5A00 ^ 16'(j);
          step("R4", {4'b0101, rg, 2'b00}, by, -1, 0, din, j == ACC - 1, din);
        end
      end else begin
        n = (len == 0) ? 1 : int'(len);
        k = 0; i = 0;
        while (k < n) begin
          din = 16'hC300 + 16'(i * 7) + a[15:0];
          step("R8", 7'b0101001, by, -1, wp[i], din, !wp[i], din);
          if (!wp[i]) k++;
          i++;
        end
      end
    end
    if (wr && rg) begin m_sync = !d[15]; m_whi = d[10]; end
    chk("R6 cfg_sync", cfg_sync, m_sync);
    chk("R6 cfg_wait_hi", cfg_wait_hi, m_whi);
    chk("R10 recov ready", req_ready, 1'b0);
    step("R10", 7'b1111000, 2'b11, -1, 0, 16'h0, 0, 16'h0);
  endtask

  task automatic reset_chk(input string r);
    chk({r, " pins"}, pins(), 7'b1111000);
    chk({r, " rsp_valid"}, rsp_valid, 1'b0);
    chk({r, " ready"}, req_ready, 1'b1);
    chk({r, " cfg"}, {cfg_sync, cfg_wait_hi}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_chk("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    reset_chk("R1 after reset");
    access(1, 0, 21'h1A2B3, 16'hBEEF, 2'b01, 0, 0);
    access(1, 0, 21'h00F0F, 16'h1234, 2'b10, 0, 0);
    access(0, 0, 21'h0C0DE, 0, 2'b11, 5, 0);
    access(0, 1, 21'h00000, 0, 2'b11, 0, 0);
    access(1, 1, 21'h00000, 16'h0400, 2'b11, 0, 0);
    access(0, 0, 21'h12345, 0, 2'b11, 4, 16'b0000_0000_0010_0110);
    access(1, 0, 21'h054AA, 16'hA55A, 2'b11, 0, 16'b011);
    access(0, 0, 21'h10001, 0, 2'b11, 0, 16'b1);
    access(0, 1, 21'h00000, 0, 2'b11, 0, 0);
    access(1, 1, 21'h00000, 16'h0000, 2'b11, 0, 0);
    access(0, 0, 21'h0ABCD, 0, 2'b11, 3, 16'b0000_0000_0001_1001);
    access(1, 0, 21'h1FFFF, 16'h00FF, 2'b01, 0, 16'b1);
    access(1, 1, 21'h00000, 16'h8400, 2'b11, 0, 0);
    access(0, 0, 21'h03003, 0, 2'b11, 7, 0);
    access(1, 0, 21'h00001, 16'h7777, 2'b10, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule